// File: doc/BRIEF.md
# LPC Bus Cycle Monitor

A passive observer for a Low Pin Count bus. On every rising edge of the bus clock it samples the active-low frame strobe and the 4-bit multiplexed address/control/data lines. From these samples it rebuilds each target bus cycle and its phases: start, type/direction, address, turn-around, SYNC, data and the closing turn-around. It drives nothing onto the bus.

When a cycle finishes, the monitor presents a result record for exactly one clock. The record holds the type nibble, the address (zero-extended to 32 bits), the single data byte, the last SYNC code and a 4-bit warning mask. I/O cycles, memory cycles and single-byte DMA-style cycles with no address phase are followed. An illegal type nibble ends the cycle at once with a flagged record. A frame strobe that returns mid-cycle drops the partial decode, and no record is produced for it.

Top module: `lpc_cycle_monitor`

## Requirements
- R1: While rst_ni is low, and after it rises, rec_valid_o is 0 and every record field is 0. A reset in the middle of a cycle discards that cycle, so no record comes from it.
- R2: A cycle begins when frame_ni is sampled low while idle. The start nibble is the last one sampled before frame_ni goes high. Only start nibble 0000 leads to decoding. Any other start value returns the monitor to idle and produces no record.
- R3: If the lad_i nibble changes between two consecutive low-frame samples, warning bit 0 is set in that cycle's record.
- R4: The type nibble is the first nibble sampled with frame_ni high. Bits [3:1] select the cycle: 000 I/O read, 001 I/O write, 010 memory read, 011 memory write, 100 DMA read, 101 DMA write, and bit 0 is ignored. A nibble of the form 11x0 or 11x1 is illegal. For an illegal nibble, a record follows one clock later with rec_kind_o equal to that nibble, warning bit 1 set, and address, data and SYNC all 0. The monitor then goes idle.
- R5: Address nibbles arrive most significant first. An I/O cycle carries 4 nibbles, reported zero-extended to 32 bits. A memory cycle carries 8 nibbles. A DMA cycle has no address phase, and its address is reported as 0.
- R6: The data byte spans two clocks, and the low nibble comes first.
- R7: A read follows the order turn-around, SYNC, data, turn-around. A write follows the order data, turn-around, SYNC, turn-around.
- R8: Each turn-around lasts two clocks. Any turn-around nibble other than 1111 sets warning bit 2.
- R9: SYNC nibbles 0101 and 0110 are wait states and repeat for as long as they are sent. Any other nibble ends the SYNC phase and is reported in rec_sync_o. A value outside {0000, 0101, 0110, 1001, 1010} sets warning bit 3.
- R10: If frame_ni is sampled low after the type nibble, the partial cycle is dropped without a record. Its warnings are cleared, and start capture begins again with that sample.
- R11: rec_valid_o is high for exactly one clock. It is high during the clock that follows the edge which sampled the second nibble of the closing turn-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock; all sampling happens on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_ni | input | 1 | Active-low frame strobe as seen on the bus |
| lad_i | input | 4 | Multiplexed address/control/data nibble |
| rec_valid_o | output | 1 | One-clock strobe marking a new record |
| rec_kind_o | output | 4 | Type/direction nibble of the reported cycle |
| rec_addr_o | output | 32 | Decoded address, zero-extended |
| rec_data_o | output | 8 | Data byte |
| rec_sync_o | output | 4 | Final SYNC nibble |
| rec_warn_o | output | 4 | Warning mask: [0] start changed, [1] illegal type, [2] bad turn-around, [3] reserved SYNC |

## Verification
A normal record appears one clock after the edge that samples the last closing turn-around nibble. An illegal-type record appears one clock after the edge that samples the type nibble. The bench drives each nibble on a falling edge and reads the record on the falling edge right after the final nibble. It reads again one falling edge later to confirm the strobe has dropped. A falling-edge counter of valid pulses shows that aborted, reset or non-target cycles add no record.

// File: rtl/lpc_mon_pkg.sv
package lpc_mon_pkg;

  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 8;
  localparam int WARN_W    = 4;
  localparam int IO_NIBS   = 4;
  localparam int MEM_NIBS  = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int TAR_CLKS  = 2;
  localparam int CNT_W     = $clog2(MEM_NIBS);

  localparam int WB_START = 0;
  localparam int WB_TYPE  = 1;
  localparam int WB_TAR   = 2;
  localparam int WB_SYNC  = 3;

  localparam logic [NIB_W-1:0] START_TARGET = 4'b0000;
  localparam logic [NIB_W-1:0] TAR_IDLE     = 4'b1111;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ADDR, PH_TAR1, PH_SYNC, PH_DATA, PH_TAR2
  } lpc_phase_e;

  function automatic int addr_nibs(input logic [NIB_W-1:0] ct);
    case (ct[3:1])
      3'b000, 3'b001: return IO_NIBS;
      3'b010, 3'b011: return MEM_NIBS;
      default:        return 0;
    endcase
  endfunction

  function automatic logic type_illegal(input logic [NIB_W-1:0] ct);
    return ct[3] & ct[2];
  endfunction

  function automatic logic sync_is_wait(input logic [NIB_W-1:0] s);
    return (s == 4'b0101) || (s == 4'b0110);
  endfunction

  function automatic logic sync_is_known(input logic [NIB_W-1:0] s);
    return (s == 4'b0000) || (s == 4'b1001) || (s == 4'b1010) || sync_is_wait(s);
  endfunction

endpackage

// File: rtl/lpc_nib_shift.sv
module lpc_nib_shift #(
  parameter int W         = 32,
  parameter bit MSN_FIRST = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         shift_i,
  input  logic [3:0]   nib_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  generate
    if (MSN_FIRST) begin : g_msn
      assign nxt = {q_o[W-5:0], nib_i};
    end else begin : g_lsn
      assign nxt = {nib_i, q_o[W-1:4]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clear_i) q_o <= '0;
    else if (shift_i) q_o <= nxt;
  end
endmodule

// File: rtl/lpc_phase_fsm.sv
module lpc_phase_fsm
  import lpc_mon_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic [NIB_W-1:0] lad_i,
  output lpc_phase_e       phase_o,
  output logic [NIB_W-1:0] ct_o,
  output logic             ev_begin_o,
  output logic             ev_start_chg_o,
  output logic             ev_type_o,
  output logic             ev_type_bad_o,
  output logic             ev_addr_o,
  output logic             ev_data_o,
  output logic             ev_tar_bad_o,
  output logic             ev_sync_o,
  output logic             ev_sync_bad_o,
  output logic             ev_done_o,
  output logic             ev_abort_o
);
  lpc_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NIB_W-1:0] start_q, ct_q;
  logic             is_wr;
  logic             mid_cycle;

  assign is_wr     = ct_q[1];
  assign mid_cycle = (phase_q != PH_IDLE) && (phase_q != PH_START);

  always_comb begin
    phase_d        = phase_q;
    cnt_d          = cnt_q;
    ev_begin_o     = 1'b0;
    ev_start_chg_o = 1'b0;
    ev_type_o      = 1'b0;
    ev_type_bad_o  = 1'b0;
    ev_addr_o      = 1'b0;
    ev_data_o      = 1'b0;
    ev_tar_bad_o   = 1'b0;
    ev_sync_o      = 1'b0;
    ev_sync_bad_o  = 1'b0;
    ev_done_o      = 1'b0;
    ev_abort_o     = 1'b0;
    case (phase_q)
      PH_IDLE: if (!frame_ni) begin
        ev_begin_o = 1'b1;
        phase_d    = PH_START;
      end
      PH_START: begin
        if (!frame_ni) begin
          ev_start_chg_o = (lad_i != start_q);
        end else if (start_q != START_TARGET) begin
          phase_d = PH_IDLE;
        end else if (type_illegal(lad_i)) begin
          ev_type_bad_o = 1'b1;
          phase_d       = PH_IDLE;
        end else begin
          ev_type_o = 1'b1;
          cnt_d     = '0;
          if (addr_nibs(lad_i) != 0) phase_d = PH_ADDR;
          else if (lad_i[1])         phase_d = PH_DATA;
          else                       phase_d = PH_TAR1;
        end
      end
      PH_ADDR: begin
        ev_addr_o = 1'b1;
        if (int'(cnt_q) == addr_nibs(ct_q) - 1) begin
          cnt_d   = '0;
          phase_d = is_wr ? PH_DATA : PH_TAR1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_TAR1: begin
        ev_tar_bad_o = (lad_i != TAR_IDLE);
        if (int'(cnt_q) == TAR_CLKS - 1) begin
          cnt_d   = '0;
          phase_d = PH_SYNC;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_SYNC: begin
        ev_sync_o     = 1'b1;
        ev_sync_bad_o = !sync_is_known(lad_i);
        if (!sync_is_wait(lad_i)) phase_d = is_wr ? PH_TAR2 : PH_DATA;
      end
      PH_DATA: begin
        ev_data_o = 1'b1;
        if (int'(cnt_q) == DATA_NIBS - 1) begin
          cnt_d   = '0;
          phase_d = is_wr ? PH_TAR1 : PH_TAR2;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_TAR2: begin
        ev_tar_bad_o = (lad_i != TAR_IDLE);
        if (int'(cnt_q) == TAR_CLKS - 1) begin
          cnt_d     = '0;
          ev_done_o = 1'b1;
          phase_d   = PH_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (mid_cycle && !frame_ni) begin
      ev_addr_o     = 1'b0;
      ev_data_o     = 1'b0;
      ev_tar_bad_o  = 1'b0;
      ev_sync_o     = 1'b0;
      ev_sync_bad_o = 1'b0;
      ev_done_o     = 1'b0;
      ev_abort_o    = 1'b1;
      cnt_d         = '0;
      phase_d       = PH_START;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      start_q <= '0;
      ct_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (!frame_ni) start_q <= lad_i;
      if (ev_type_o) ct_q    <= lad_i;
    end
  end

  assign phase_o = phase_q;
  assign ct_o    = ct_q;
endmodule

// File: rtl/lpc_rec_out.sv
module lpc_rec_out
  import lpc_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  lad_i,
  input  logic [NIB_W-1:0]  ct_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ev_begin_i,
  input  logic              ev_abort_i,
  input  logic              ev_type_i,
  input  logic              ev_sync_i,
  input  logic              ev_start_chg_i,
  input  logic              ev_type_bad_i,
  input  logic              ev_tar_bad_i,
  input  logic              ev_sync_bad_i,
  input  logic              ev_done_i,
  output logic              rec_valid_o,
  output logic [NIB_W-1:0]  rec_kind_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic [NIB_W-1:0]  rec_sync_o,
  output logic [WARN_W-1:0] rec_warn_o
);
  logic [NIB_W-1:0]  sync_q;
  logic [WARN_W-1:0] warn_q, warn_now, warn_sum;

  always_comb begin
    warn_now           = '0;
    warn_now[WB_START] = ev_start_chg_i;
    warn_now[WB_TYPE]  = ev_type_bad_i;
    warn_now[WB_TAR]   = ev_tar_bad_i;
    warn_now[WB_SYNC]  = ev_sync_bad_i;
  end
  assign warn_sum = warn_q | warn_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= '0;
      warn_q      <= '0;
      rec_valid_o <= 1'b0;
      rec_kind_o  <= '0;
      rec_addr_o  <= '0;
      rec_data_o  <= '0;
      rec_sync_o  <= '0;
      rec_warn_o  <= '0;
    end else begin
      if (ev_begin_i || ev_abort_i) warn_q <= '0;
      else                          warn_q <= warn_sum;
      if (ev_type_i)      sync_q <= '0;
      else if (ev_sync_i) sync_q <= lad_i;
      rec_valid_o <= ev_done_i || ev_type_bad_i;
      if (ev_type_bad_i) begin
        rec_kind_o <= lad_i;
        rec_addr_o <= '0;
        rec_data_o <= '0;
        rec_sync_o <= '0;
        rec_warn_o <= warn_sum;
      end else if (ev_done_i) begin
        rec_kind_o <= ct_i;
        rec_addr_o <= addr_i;
        rec_data_o <= data_i;
        rec_sync_o <= sync_q;
        rec_warn_o <= warn_sum;
      end
    end
  end
endmodule

// File: rtl/lpc_cycle_monitor.sv
module lpc_cycle_monitor
  import lpc_mon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic [NIB_W-1:0]  lad_i,
  output logic              rec_valid_o,
  output logic [NIB_W-1:0]  rec_kind_o,
  output logic [ADDR_W-1:0] rec_addr_o,
  output logic [DATA_W-1:0] rec_data_o,
  output logic [NIB_W-1:0]  rec_sync_o,
  output logic [WARN_W-1:0] rec_warn_o
);
  lpc_phase_e        phase;
  logic [NIB_W-1:0]  ct;
  logic [ADDR_W-1:0] addr_acc;
  logic [DATA_W-1:0] data_acc;
  logic ev_begin, ev_start_chg, ev_type, ev_type_bad, ev_addr, ev_data;
  logic ev_tar_bad, ev_sync, ev_sync_bad, ev_done, ev_abort;

  lpc_phase_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .lad_i(lad_i),
    .phase_o(phase), .ct_o(ct),
    .ev_begin_o(ev_begin), .ev_start_chg_o(ev_start_chg),
    .ev_type_o(ev_type), .ev_type_bad_o(ev_type_bad),
    .ev_addr_o(ev_addr), .ev_data_o(ev_data),
    .ev_tar_bad_o(ev_tar_bad), .ev_sync_o(ev_sync),
    .ev_sync_bad_o(ev_sync_bad), .ev_done_o(ev_done), .ev_abort_o(ev_abort)
  );

  lpc_nib_shift #(.W(ADDR_W), .MSN_FIRST(1'b1)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(ev_type), .shift_i(ev_addr),
    .nib_i(lad_i), .q_o(addr_acc)
  );

  lpc_nib_shift #(.W(DATA_W), .MSN_FIRST(1'b0)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(ev_type), .shift_i(ev_data),
    .nib_i(lad_i), .q_o(data_acc)
  );

  lpc_rec_out u_rec (
    .clk_i(clk_i), .rst_ni(rst_ni), .lad_i(lad_i), .ct_i(ct),
    .addr_i(addr_acc), .data_i(data_acc),
    .ev_begin_i(ev_begin), .ev_abort_i(ev_abort), .ev_type_i(ev_type),
    .ev_sync_i(ev_sync), .ev_start_chg_i(ev_start_chg),
    .ev_type_bad_i(ev_type_bad), .ev_tar_bad_i(ev_tar_bad),
    .ev_sync_bad_i(ev_sync_bad), .ev_done_i(ev_done),
    .rec_valid_o(rec_valid_o), .rec_kind_o(rec_kind_o), .rec_addr_o(rec_addr_o),
    .rec_data_o(rec_data_o), .rec_sync_o(rec_sync_o), .rec_warn_o(rec_warn_o)
  );
endmodule

// File: rtl/lpc_monitor_sva.sv
module lpc_monitor_sva
  import lpc_mon_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_ni,
  input lpc_phase_e        phase_i,
  input logic              rec_valid_i,
  input logic [NIB_W-1:0]  rec_kind_i,
  input logic [ADDR_W-1:0] rec_addr_i,
  input logic [NIB_W-1:0]  rec_sync_i,
  input logic [WARN_W-1:0] rec_warn_i
);
  AST_VALID_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |=> !rec_valid_i); // R11

  AST_RECORD_AFTER_FRAME_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |-> $past(frame_ni)); // R10

  AST_ABORT_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_ni && phase_i != PH_IDLE && phase_i != PH_START) |=> phase_i == PH_START); // R10

  AST_ILLEGAL_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_kind_i[3:2] == 2'b11) |-> rec_warn_i[WB_TYPE]); // R4

  AST_TYPE_FLAG_ONLY_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_warn_i[WB_TYPE]) |-> rec_kind_i[3:2] == 2'b11); // R4

  AST_IO_ADDR_16BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && rec_kind_i[3:2] == 2'b00) |-> rec_addr_i[31:16] == 16'h0); // R5

  AST_SYNC_NOT_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |-> (rec_sync_i != 4'b0101 && rec_sync_i != 4'b0110)); // R9
endmodule

bind lpc_cycle_monitor lpc_monitor_sva i_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_ni(frame_ni), .phase_i(phase),
  .rec_valid_i(rec_valid_o), .rec_kind_i(rec_kind_o), .rec_addr_i(rec_addr_o),
  .rec_sync_i(rec_sync_o), .rec_warn_i(rec_warn_o)
);

// File: tb/test_lpc_cycle_monitor.sv
`timescale 1ns/1ps
module test_lpc_cycle_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  lad = 4'hF;
  logic        rec_valid;
  logic [3:0]  rec_kind, rec_sync, rec_warn;
  logic [31:0] rec_addr;
  logic [7:0]  rec_data;
  int checks = 0;
  int errors = 0;
  int vcount = 0;

  always #2.5 clk = ~clk;

  lpc_cycle_monitor i_lpc_cycle_monitor (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .lad_i(lad),
    .rec_valid_o(rec_valid), .rec_kind_o(rec_kind), .rec_addr_o(rec_addr),
    .rec_data_o(rec_data), .rec_sync_o(rec_sync), .rec_warn_o(rec_warn)
  );

  always @(negedge clk) if (rec_valid === 1'b1) vcount++;

  typedef struct packed {
    logic [3:0]  ct;
    logic [31:0] addr;
    logic [7:0]  data;
    logic [3:0]  nwait;
    logic [3:0]  sync;
    logic [3:0]  tarv;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 32'h0000_1234, 8'hA5, 4'd0, 4'h0, 4'hF},
    '{4'h2, 32'hFFFF_BEEF, 8'h3C, 4'd2, 4'h0, 4'hF},
    '{4'h4, 32'h89AB_CDEF, 8'h7E, 4'd1, 4'hA, 4'hF},
    '{4'h6, 32'h1357_9BDF, 8'hC4, 4'd0, 4'h0, 4'h7},
    '{4'h8, 32'hDEAD_0000, 8'h5A, 4'd0, 4'h9, 4'hF},
    '{4'h4, 32'h0000_0000, 8'h11, 4'd3, 4'h3, 4'hF},
    '{4'h3, 32'h0000_4321, 8'h99, 4'd1, 4'h0, 4'hF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [3:0] n);
    @(negedge clk);
    frame_n = f;
    lad     = n;
  endtask

  task automatic send_cycle(input vec_t v, input logic [3:0] xwarn, input string req);
    int alen;
    logic [31:0] eaddr;
    logic [3:0]  ew;
    case (v.ct[3:1])
      3'b000, 3'b001: begin alen = 4; eaddr = {16'h0, v.addr[15:0]}; end
      3'b010, 3'b011: begin alen = 8; eaddr = v.addr; end
      default:        begin alen = 0; eaddr = 32'h0; end
    endcase
    ew = xwarn;
    if (v.tarv != 4'hF) ew[2] = 1'b1;
    case (v.sync)
      4'h0, 4'h5, 4'h6, 4'h9, 4'hA: ;
      default: ew[3] = 1'b1;
    endcase
    drive(1'b0, 4'h0);
    drive(1'b1, v.ct);
    for (int i = alen - 1; i >= 0; i--) drive(1'b1, v.addr[i*4 +: 4]);
    if (v.ct[1]) begin
      drive(1'b1, v.data[3:0]); drive(1'b1, v.data[7:4]);
      drive(1'b1, v.tarv); drive(1'b1, v.tarv);
      for (int i = 0; i < int'(v.nwait); i++) drive(1'b1, (i % 2 == 0) ? 4'h5 : 4'h6);
      drive(1'b1, v.sync);
    end else begin
      drive(1'b1, v.tarv); drive(1'b1, v.tarv);
      for (int i = 0; i < int'(v.nwait); i++) drive(1'b1, (i % 2 == 0) ? 4'h6 : 4'h5);
      drive(1'b1, v.sync);
      drive(1'b1, v.data[3:0]); drive(1'b1, v.data[7:4]);
    end
    drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
    @(negedge clk);
    frame_n = 1'b1;
    lad     = 4'hF;
    chk({req, " R11 valid after closing turn-around"}, {31'h0, rec_valid}, 32'h1);
    chk({req, " R4 kind"}, {28'h0, rec_kind}, {28'h0, v.ct});
    chk({req, " R5 address"}, rec_addr, eaddr);
    chk({req, " R6 data"}, {24'h0, rec_data}, {24'h0, v.data});
    chk({req, " R9 sync"}, {28'h0, rec_sync}, {28'h0, v.sync});
    chk({req, " R8 warn"}, {28'h0, rec_warn}, {28'h0, ew});
    @(negedge clk);
    chk({req, " R11 valid one clock"}, {31'h0, rec_valid}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int vbase;
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'h0, rec_valid}, 32'h0);
    chk("R1 reset addr", rec_addr, 32'h0);
    chk("R1 reset warn", {28'h0, rec_warn}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) send_cycle(VECS[k], 4'h0, $sformatf("vec%0d R7", k));

    // R2 R3: start held several clocks, value changes
    drive(1'b0, 4'hF);
    drive(1'b0, 4'h0);
    send_cycle(VECS[0], 4'h1, "R3 start change");

    // R2: start held steady over several clocks, no warning
    drive(1'b0, 4'h0);
    drive(1'b0, 4'h0);
    send_cycle(VECS[2], 4'h0, "R2 long start");

    // R2: non-target start produces no record
    vbase = vcount;
    drive(1'b0, 4'hF);
    drive(1'b1, 4'h0);
    for (int i = 0; i < 12; i++) drive(1'b1, 4'h0);
    drive(1'b1, 4'hF);
    @(negedge clk);
    chk("R2 non-target start no record", vcount - vbase, 32'h0);

    // R4: illegal type nibble
    drive(1'b0, 4'h0);
    drive(1'b1, 4'hD);
    @(negedge clk);
    frame_n = 1'b1; lad = 4'hF;
    chk("R4 illegal valid", {31'h0, rec_valid}, 32'h1);
    chk("R4 illegal kind", {28'h0, rec_kind}, 32'hD);
    chk("R4 illegal warn", {28'h0, rec_warn}, 32'h2);
    chk("R4 illegal addr", rec_addr, 32'h0);
    @(negedge clk);
    chk("R4 illegal one clock", {31'h0, rec_valid}, 32'h0);

    // R10: abort mid-address, warning from aborted part must not carry over
    vbase = vcount;
    drive(1'b0, 4'h3);
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h4);
    drive(1'b1, 4'h1); drive(1'b1, 4'h2); drive(1'b1, 4'h3);
    drive(1'b0, 4'h0);
    v = VECS[6];
    send_cycle(v, 4'h0, "R10 after abort");
    chk("R10 single record", vcount - vbase, 32'h1);

    // R1: reset in the middle of a cycle
    vbase = vcount;
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h6);
    drive(1'b1, 4'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset valid", {31'h0, rec_valid}, 32'h0);
    chk("R1 mid reset kind", {28'h0, rec_kind}, 32'h0);
    chk("R1 mid reset data", {24'h0, rec_data}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++) drive(1'b1, 4'h0);
    drive(1'b1, 4'hF);
    @(negedge clk);
    chk("R1 no record after reset", vcount - vbase, 32'h0);
    send_cycle(VECS[3], 4'h0, "R1 recovery");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule